// File: doc/BRIEF.md
# MMD Indirect Access Sequencer

This block turns one high-level access to a 16-bit register in a managed device (an MMD) into the fixed series of Clause 22 transactions that a PHY needs when it only understands Clause 22 frames. A command names the PHY address, the device address, the 16-bit target register, and the write data or the clear and set masks. The block then drives a simple request/acknowledge port that an existing MDIO frame engine serves, one transaction at a time.

Every access goes through two Clause 22 registers: a control register that selects the device and the access function, and an address/data register that first takes the target address and then carries the data. A read-modify-write runs a complete indirect read, merges the value with the masks, and then runs a complete indirect write. When the sequence ends, the block gives a one-cycle done pulse. That pulse carries an error flag if the frame engine reported a failure, and the value read is presented alongside it.

Top module: `mmd_seq`

## Requirements
- R1: Each pass issues four transactions in this fixed order. (1) A write to Clause 22 register 0x0D with the address function. (2) A write to register 0x0E carrying the target register address. (3) A write to register 0x0D with the data function. (4) An access to register 0x0E.
- R2: A control word puts the function code in bits 15:14: 00 is the address function and 01 is data with no increment. The device address goes in bits 4:0 and all other bits are zero. Only the low 5 bits of the 8-bit `cmd_devad` are used, so higher bits never reach the function field.
- R3: A read is selected by `cmd_op` 0, and code 3 also acts as a read. Its fourth transaction is a Clause 22 read of 0x0E, and the 16 bits returned appear on `rdata` while `done` is high.
- R4: A write (`cmd_op` 1) ends with a Clause 22 write of 0x0E carrying `cmd_wdata`, for four transactions in all.
- R5: A read-modify-write (`cmd_op` 2) issues exactly eight transactions: a full read pass, then a full write pass. The write pass writes (read value AND NOT `cmd_clr`) OR `cmd_set`, so a bit that is both cleared and set ends up set. `rdata` returns the value read before the merge.
- R6: Every transaction of one command uses the PHY address given with that command.
- R7: If a transaction is acknowledged with `mdio_err` high, no further transaction is issued. `done` and `err` are both high in the next cycle.
- R8: A command is taken only when `cmd_valid` is high while `busy` is low. `busy` rises in the cycle after acceptance and falls as `done` is raised. A `cmd_valid` seen while busy is dropped without effect.
- R9: Only one request is outstanding at a time. `mdio_req` stays high with stable fields until `mdio_ack` arrives, and it is low whenever the block is idle.
- R10: After reset, `busy`, `done`, `err` and `mdio_req` are low. `done` lasts exactly one cycle per command, and `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| cmd_phy | input | 5 | PHY address for all transactions |
| cmd_devad | input | 8 | Device address (low 5 bits used) |
| cmd_reg | input | 16 | Target register address |
| cmd_wdata | input | 16 | Write data |
| cmd_clr | input | 16 | Bits to clear on read-modify-write |
| cmd_set | input | 16 | Bits to set on read-modify-write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| rdata | output | 16 | Register value read |
| mdio_req | output | 1 | Downstream request |
| mdio_wr | output | 1 | 1 write, 0 read |
| mdio_phy | output | 5 | Downstream PHY address |
| mdio_reg | output | 5 | Downstream Clause 22 register |
| mdio_wdata | output | 16 | Downstream write data |
| mdio_ack | input | 1 | Transaction complete |
| mdio_rdata | input | 16 | Read data from the engine |
| mdio_err | input | 1 | Transaction failed |

## Verification
The step counter and the pass flag decide which register is addressed and what is written. A step that is skipped or repeated therefore shows on the next request as a wrong `mdio_reg` or a wrong control word, one acknowledge after the fault. A merge fault, or a read value that was never captured, appears only in the last write of a read-modify-write pass, or on `rdata` with `done`. For that reason the bench records every downstream transaction and compares each one with a sequence it builds on its own. A state machine that fails to leave its error path shows up as an extra transaction or a missing `done` within a few cycles.

// File: rtl/mmd_seq_pkg.sv
package mmd_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_READ2 = 2'd3
  } mmd_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam logic [4:0] C22_CTRL_REG = 5'h0D;
  localparam logic [4:0] C22_DATA_REG = 5'h0E;
  localparam logic [1:0] FUNC_ADDR    = 2'b00;
  localparam logic [1:0] FUNC_DATA    = 2'b01;
  localparam int         PASS_STEPS   = 4;
endpackage

// File: rtl/mmd_step_decode.sv
module mmd_step_decode #(
  parameter int DW       = 16,
  parameter int REG_W    = 5,
  parameter int DEV_IN_W = 8,
  parameter int DEV_W    = 5,
  parameter int STEP_W   = 2
) (
  input  logic [STEP_W-1:0]   step,
  input  logic                rd_pass,
  input  logic [DEV_IN_W-1:0] dev,
  input  logic [DW-1:0]       target_reg,
  input  logic [DW-1:0]       wval,
  output logic                txn_wr,
  output logic [REG_W-1:0]    txn_reg,
  output logic [DW-1:0]       txn_wdata
);
  import mmd_seq_pkg::*;

  localparam logic [DW-1:0] DEV_MASK = DW'((1 << DEV_W) - 1);

  function automatic logic [DW-1:0] ctrl_word(input logic [1:0] fn,
                                              input logic [DEV_IN_W-1:0] d);
    logic [DW-1:0] w;
    w = '0;
    w[DW-1 -: 2] = fn;
    return w | (DW'(d) & DEV_MASK);
  endfunction

  always_comb begin
    txn_wr    = 1'b1;
    txn_reg   = REG_W'(C22_CTRL_REG);
    txn_wdata = '0;
    case (step)
      STEP_W'(0): begin
        txn_reg   = REG_W'(C22_CTRL_REG);
        txn_wdata = ctrl_word(FUNC_ADDR, dev);
      end
      STEP_W'(1): begin
        txn_reg   = REG_W'(C22_DATA_REG);
        txn_wdata = target_reg;
      end
      STEP_W'(2): begin
        txn_reg   = REG_W'(C22_CTRL_REG);
        txn_wdata = ctrl_word(FUNC_DATA, dev);
      end
      default: begin
        txn_reg   = REG_W'(C22_DATA_REG);
        txn_wr    = ~rd_pass;
        txn_wdata = rd_pass ? '0 : wval;
      end
    endcase
  end
endmodule

// File: rtl/mmd_rmw_merge.sv
module mmd_rmw_merge #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] current,
  input  logic [DW-1:0] clr_mask,
  input  logic [DW-1:0] set_mask,
  output logic [DW-1:0] merged
);
  function automatic logic [DW-1:0] merge_val(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] c,
                                              input logic [DW-1:0] s);
    return (cur & ~c) | s;
  endfunction

  assign merged = merge_val(current, clr_mask, set_mask);
endmodule

// File: rtl/mmd_seq_fsm.sv
module mmd_seq_fsm #(
  parameter int DW       = 16,
  parameter int PHY_W    = 5,
  parameter int DEV_IN_W = 8,
  parameter int STEP_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [PHY_W-1:0]    cmd_phy,
  input  logic [DEV_IN_W-1:0] cmd_devad,
  input  logic [DW-1:0]       cmd_reg,
  input  logic [DW-1:0]       cmd_wdata,
  input  logic [DW-1:0]       cmd_clr,
  input  logic [DW-1:0]       cmd_set,
  input  logic                ack,
  input  logic                ack_err,
  input  logic [DW-1:0]       ack_rdata,
  input  logic [DW-1:0]       merged,
  output logic                busy,
  output logic                accept,
  output logic                txn_fire,
  output logic [STEP_W-1:0]   step,
  output logic                rd_pass,
  output logic [PHY_W-1:0]    lat_phy,
  output logic [DEV_IN_W-1:0] lat_dev,
  output logic [DW-1:0]       lat_reg,
  output logic [DW-1:0]       lat_clr,
  output logic [DW-1:0]       lat_set,
  output logic [DW-1:0]       wval,
  output logic                done,
  output logic                err,
  output logic [DW-1:0]       rdata
);
  import mmd_seq_pkg::*;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PASS_STEPS - 1);

  seq_state_e state;
  logic       chain_write;
  logic       last_step;

  assign busy      = (state == ST_RUN);
  assign accept    = cmd_valid && (state == ST_IDLE);
  assign txn_fire  = busy && ack;
  assign last_step = (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      step        <= '0;
      rd_pass     <= 1'b0;
      chain_write <= 1'b0;
      lat_phy     <= '0;
      lat_dev     <= '0;
      lat_reg     <= '0;
      lat_clr     <= '0;
      lat_set     <= '0;
      wval        <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      rdata       <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (accept) begin
        state       <= ST_RUN;
        step        <= '0;
        rd_pass     <= (mmd_op_e'(cmd_op) != OP_WRITE);
        chain_write <= (mmd_op_e'(cmd_op) == OP_RMW);
        lat_phy     <= cmd_phy;
        lat_dev     <= cmd_devad;
        lat_reg     <= cmd_reg;
        lat_clr     <= cmd_clr;
        lat_set     <= cmd_set;
        wval        <= cmd_wdata;
      end else if (txn_fire) begin
        if (ack_err) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          err   <= 1'b1;
        end else if (!last_step) begin
          step <= step + 1'b1;
        end else if (rd_pass && chain_write) begin
          rdata       <= ack_rdata;
          wval        <= merged;
          rd_pass     <= 1'b0;
          chain_write <= 1'b0;
          step        <= '0;
        end else begin
          if (rd_pass) rdata <= ack_rdata;
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mmd_seq.sv
module mmd_seq #(
  parameter int DW       = 16,
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int DEV_IN_W = 8,
  parameter int DEV_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [PHY_W-1:0]    cmd_phy,
  input  logic [DEV_IN_W-1:0] cmd_devad,
  input  logic [DW-1:0]       cmd_reg,
  input  logic [DW-1:0]       cmd_wdata,
  input  logic [DW-1:0]       cmd_clr,
  input  logic [DW-1:0]       cmd_set,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [DW-1:0]       rdata,
  output logic                mdio_req,
  output logic                mdio_wr,
  output logic [PHY_W-1:0]    mdio_phy,
  output logic [REG_W-1:0]    mdio_reg,
  output logic [DW-1:0]       mdio_wdata,
  input  logic                mdio_ack,
  input  logic [DW-1:0]       mdio_rdata,
  input  logic                mdio_err
);
  localparam int STEP_W = $clog2(mmd_seq_pkg::PASS_STEPS);

  logic                accept;
  logic                txn_fire;
  logic [STEP_W-1:0]   step;
  logic                rd_pass;
  logic [PHY_W-1:0]    lat_phy;
  logic [DEV_IN_W-1:0] lat_dev;
  logic [DW-1:0]       lat_reg;
  logic [DW-1:0]       lat_clr;
  logic [DW-1:0]       lat_set;
  logic [DW-1:0]       wval;
  logic [DW-1:0]       merged;

  mmd_seq_fsm #(.DW(DW), .PHY_W(PHY_W), .DEV_IN_W(DEV_IN_W), .STEP_W(STEP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_phy(cmd_phy),
    .cmd_devad(cmd_devad), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .cmd_clr(cmd_clr), .cmd_set(cmd_set),
    .ack(mdio_ack), .ack_err(mdio_err), .ack_rdata(mdio_rdata), .merged(merged),
    .busy(busy), .accept(accept), .txn_fire(txn_fire), .step(step),
    .rd_pass(rd_pass), .lat_phy(lat_phy), .lat_dev(lat_dev), .lat_reg(lat_reg),
    .lat_clr(lat_clr), .lat_set(lat_set), .wval(wval),
    .done(done), .err(err), .rdata(rdata)
  );

  mmd_rmw_merge #(.DW(DW)) u_merge (
    .current(mdio_rdata), .clr_mask(lat_clr), .set_mask(lat_set), .merged(merged)
  );

  mmd_step_decode #(.DW(DW), .REG_W(REG_W), .DEV_IN_W(DEV_IN_W), .DEV_W(DEV_W),
                    .STEP_W(STEP_W)) u_dec (
    .step(step), .rd_pass(rd_pass), .dev(lat_dev), .target_reg(lat_reg),
    .wval(wval), .txn_wr(mdio_wr), .txn_reg(mdio_reg), .txn_wdata(mdio_wdata)
  );

  assign mdio_req = busy;
  assign mdio_phy = lat_phy;
endmodule

// File: rtl/mmd_seq_chk.sv
module mmd_seq_chk #(
  parameter int DW     = 16,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int STEP_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_op,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mdio_req,
  input logic              mdio_wr,
  input logic [PHY_W-1:0]  mdio_phy,
  input logic [REG_W-1:0]  mdio_reg,
  input logic [DW-1:0]     mdio_wdata,
  input logic              mdio_ack,
  input logic              mdio_err,
  input logic              accept,
  input logic              txn_fire,
  input logic [STEP_W-1:0] step
);
  logic [3:0] fire_cnt;
  logic       was_rmw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire_cnt <= '0;
      was_rmw  <= 1'b0;
    end else if (accept) begin
      fire_cnt <= '0;
      was_rmw  <= (cmd_op == 2'd2);
    end else if (txn_fire) begin
      fire_cnt <= fire_cnt + 1'b1;
    end
  end

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fire && !mdio_err && (step != STEP_W'(3)) |=> step == $past(step) + 1'b1); // R1

  AST_CTRL_WORD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && mdio_wr && (mdio_reg == REG_W'(5'h0D)) |->
      (mdio_wdata[DW-1] == 1'b0) && (mdio_wdata[DW-3:5] == '0)); // R2

  AST_TXN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> fire_cnt == (was_rmw ? 4'd8 : 4'd4)); // R5

  AST_PHY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mdio_phy)); // R6

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fire && mdio_err |=> done && err && !mdio_req); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && !mdio_ack |=> mdio_req && $stable(mdio_wr) && $stable(mdio_reg)
      && $stable(mdio_wdata)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_req); // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind mmd_seq mmd_seq_chk #(.DW(DW), .PHY_W(PHY_W), .REG_W(REG_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .busy(busy), .done(done), .err(err),
  .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
  .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack), .mdio_err(mdio_err),
  .accept(accept), .txn_fire(txn_fire), .step(step)
);

// File: tb/tb_mmd_seq.sv
`timescale 1ns/1ps
module tb_mmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [4:0]  cmd_phy = '0;
  logic [7:0]  cmd_devad = '0;
  logic [15:0] cmd_reg = '0, cmd_wdata = '0, cmd_clr = '0, cmd_set = '0;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic        mdio_req, mdio_wr;
  logic [4:0]  mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata;
  logic        mdio_ack = 1'b0;
  logic [15:0] mdio_rdata = '0;
  logic        mdio_err = 1'b0;

  int n_cmp = 0, n_bad = 0;

  mmd_seq dut (.*);

  always #2 clk = ~clk;

  // responder model and transaction log
  logic        lg_wr [16];
  logic [4:0]  lg_phy[16];
  logic [4:0]  lg_reg[16];
  logic [15:0] lg_wd [16];
  int          lg_n = 0;
  int          err_at = -1;
  int          wait_cnt = 0;
  int          done_cnt = 0;
  logic [15:0] m_ctrl = '0, m_addr = '0;

  function automatic logic [15:0] peek_val(input logic [15:0] a, input logic [15:0] c);
    return a ^ 16'h5A3C ^ {8'h00, c[7:0]};
  endfunction

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mdio_ack) begin
      mdio_ack = 1'b0;
      mdio_err = 1'b0;
      wait_cnt = 0;
    end else if (mdio_req) begin
      if (wait_cnt >= 1) begin
        if (lg_n < 16) begin
          lg_wr[lg_n]  = mdio_wr;
          lg_phy[lg_n] = mdio_phy;
          lg_reg[lg_n] = mdio_reg;
          lg_wd[lg_n]  = mdio_wdata;
        end
        mdio_err = (lg_n == err_at);
        if (mdio_wr && mdio_reg == 5'h0D) m_ctrl = mdio_wdata;
        else if (mdio_wr && mdio_reg == 5'h0E && m_ctrl[15:14] == 2'b00) m_addr = mdio_wdata;
        mdio_rdata = peek_val(m_addr, m_ctrl);
        lg_n++;
        mdio_ack = 1'b1;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // vector: op, phy, dev, reg, wdata, clr, set
  localparam int NV = 6;
  localparam logic [78:0] VEC [NV] = '{
    {2'd0, 5'd3,  8'h1F, 16'hCA00, 16'h0000, 16'h0000, 16'h0000},
    {2'd1, 5'd0,  8'h01, 16'h0834, 16'h0801, 16'h0000, 16'h0000},
    {2'd2, 5'd7,  8'h03, 16'h1234, 16'h0000, 16'h00F0, 16'h0F00},
    {2'd2, 5'd31, 8'hFF, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h8001},
    {2'd1, 5'd21, 8'hE5, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000},
    {2'd3, 5'd9,  8'h20, 16'h00AA, 16'h0000, 16'h0000, 16'h0000}
  };

  // expected transaction: {wr, reg, wdata}
  function automatic logic [21:0] exp_txn(input int i, input logic [1:0] op,
      input logic [7:0] dev, input logic [15:0] rg, input logic [15:0] wd,
      input logic [15:0] cl, input logic [15:0] st);
    logic [15:0] cur, nv;
    logic        rdp;
    int          k;
    k   = i % 4;
    rdp = (op != 2'd1) && !(op == 2'd2 && i >= 4);
    cur = peek_val(rg, {11'b0, dev[4:0]});
    for (int b = 0; b < 16; b++) nv[b] = st[b] ? 1'b1 : (cl[b] ? 1'b0 : cur[b]);
    if (op == 2'd1) nv = wd;
    case (k)
      0: return {1'b1, 5'h0D, 16'h0000 | {11'b0, dev[4:0]}};
      1: return {1'b1, 5'h0E, rg};
      2: return {1'b1, 5'h0D, 16'h4000 | {11'b0, dev[4:0]}};
      default: return rdp ? {1'b0, 5'h0E, 16'h0000} : {1'b1, 5'h0E, nv};
    endcase
  endfunction

  task automatic issue(input logic [78:0] v);
    @(negedge clk);
    {cmd_op, cmd_phy, cmd_devad, cmd_reg, cmd_wdata, cmd_clr, cmd_set} = v;
    lg_n = 0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output logic got_err, output logic [15:0] got_rd, output logic seen);
    seen = 1'b0; got_err = 1'b0; got_rd = '0;
    for (int c = 0; c < 200 && !seen; c++) begin
      if (done) begin seen = 1'b1; got_err = err; got_rd = rdata; end
      else @(negedge clk);
    end
  endtask

  task automatic run_vec(input logic [78:0] v);
    logic [1:0]  op;
    logic [4:0]  ph;
    logic [7:0]  dv;
    logic [15:0] rg, wd, cl, st, erd;
    logic        e, s;
    logic [15:0] rd;
    int          nexp;
    {op, ph, dv, rg, wd, cl, st} = v;
    issue(v);
    wait_done(e, rd, s);
    check(s, "R8", "done seen", 32'(s), 32'd1);
    check(!e, "R10", "err clear", 32'(e), 32'd0);
    nexp = (op == 2'd2) ? 8 : 4;
    check(lg_n == nexp, "R5", "transaction count", 32'(lg_n), 32'(nexp));
    for (int i = 0; i < nexp && i < lg_n; i++) begin
      logic [21:0] x;
      x = exp_txn(i, op, dv, rg, wd, cl, st);
      if (x[21])
        check({lg_wr[i], lg_reg[i], lg_wd[i]} == x, "R1", $sformatf("txn %0d (R2 R4)", i),
              32'({lg_wr[i], lg_reg[i], lg_wd[i]}), 32'(x));
      else
        check({lg_wr[i], lg_reg[i]} == x[21:16], "R3", $sformatf("txn %0d read", i),
              32'({lg_wr[i], lg_reg[i]}), 32'(x[21:16]));
      check(lg_phy[i] == ph, "R6", $sformatf("txn %0d phy", i), 32'(lg_phy[i]), 32'(ph));
    end
    if (op != 2'd1) begin
      erd = peek_val(rg, {11'b0, dv[4:0]});
      check(rd == erd, "R3", "rdata", 32'(rd), 32'(erd));
    end
    @(negedge clk);
    check(!done, "R10", "done one cycle", 32'(done), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic        e, s;
    logic [15:0] rd;
    int          dc;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !mdio_req, "R10", "reset state",
          32'({busy, done, err, mdio_req}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mdio_req, "R9", "idle no request", 32'(mdio_req), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R7: error on the sixth transaction of a read-modify-write
    err_at = 5;
    issue({2'd2, 5'd4, 8'h1F, 16'h0100, 16'h0, 16'h0001, 16'h0002});
    wait_done(e, rd, s);
    check(s && e, "R7", "done with err", 32'({s, e}), 32'h3);
    repeat (5) @(negedge clk);
    check(lg_n == 6, "R7", "no txn after error", 32'(lg_n), 32'd6);
    check(!busy && !mdio_req, "R7", "idle after error", 32'({busy, mdio_req}), 32'd0);

    // R7: error on the very first transaction of a read
    err_at = 0;
    issue({2'd0, 5'd2, 8'h05, 16'h0042, 16'h0, 16'h0, 16'h0});
    wait_done(e, rd, s);
    repeat (3) @(negedge clk);
    check(s && e && lg_n == 1, "R7", "stop at first", 32'({s, e, 8'(lg_n)}), 32'h301);
    err_at = -1;

    // R8: a command presented while busy is ignored
    issue({2'd0, 5'd6, 8'h02, 16'h0077, 16'h0, 16'h0, 16'h0});
    @(negedge clk);
    check(busy, "R8", "busy during command", 32'(busy), 32'd1);
    {cmd_op, cmd_phy, cmd_devad, cmd_reg, cmd_wdata} = {2'd1, 5'd17, 8'h09, 16'hBEEF, 16'h1111};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    dc = done_cnt;
    wait_done(e, rd, s);
    repeat (12) @(negedge clk);
    check(lg_n == 4, "R8", "txn count with ignored cmd", 32'(lg_n), 32'd4);
    check(lg_phy[3] == 5'd6 && !lg_wr[3], "R8", "last txn from first cmd",
          32'({lg_phy[3], lg_wr[3]}), 32'({5'd6, 1'b0}));
    check(done_cnt == dc + 1, "R8", "single done", 32'(done_cnt), 32'(dc + 1));
    check(rd == peek_val(16'h0077, 16'h0002), "R3", "rdata of kept cmd",
          32'(rd), 32'(peek_val(16'h0077, 16'h0002)));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule